// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Controller

This controller follows the low-power state of an SDRAM device from the clock-enable input. On every clock edge it compares the clock-enable level seen on the previous edge with the level seen now, and combines that pair with the command on the chip-select, row-strobe, column-strobe and write-enable pins and with the bank status. From these it moves between four states: normal running, power down, self refresh and clock suspend. A fifth state covers the wait that follows a self-refresh exit.

The controller drives a gate signal that the surrounding logic uses to stop the internal clock while the device sleeps. It also raises a one-cycle error pulse when an entry or exit breaks the rules. The recovery wait after self refresh is a parameter in clock cycles, counted down by a small timer. Command decoding beyond the four pins, refresh addressing and analog timing belong to other blocks.

Command encodings below are given as {cs_n, ras_n, cas_n, we_n}. "Idle command" means deselect (cs_n = 1, other pins ignored) or no-operation (4'b0111). "Refresh" means 4'b0001. Any other code with cs_n = 0 is an "other command". State codes on `pwr_state`: 0 = run, 1 = power down, 2 = self refresh, 3 = clock suspend, 4 = self-refresh recovery. All state and error outputs are registered, so a change appears after the clock edge that samples the cause.

Top module: `sdram_pwr_ctl`

## Requirements
- R1: While clock-enable is high on both the previous and the current edge in the run state, the state stays run (0) with no error.
- R2: In run, when `all_idle` is high and `bank_active` is low, clock-enable falling (high before, low now) with the refresh command moves the state to self refresh (2).
- R3: Under the same bank condition, clock-enable falling with deselect or no-operation moves the state to power down (1) with no error.
- R4: Under the same bank condition, clock-enable falling with any other command raises `err` for one cycle and moves the state to power down (1).
- R5: Power down and self refresh are held for as long as clock-enable stays low, whatever the command pins carry, with no error.
- R6: Clock-enable rising in self refresh moves the state to recovery (4), which lasts exactly RECOV_CYC cycles and then returns to run. If the exit edge carries a command other than deselect or no-operation, `err` pulses, but the recovery still runs.
- R7: Clock-enable rising in power down returns the state to run on that edge, with no error for any command.
- R8: Any command other than deselect or no-operation sampled in recovery raises `err` for one cycle and does not change how long recovery lasts.
- R9: In run, when `all_idle` is low or `bank_active` is high, clock-enable falling enters clock suspend (3). Suspend holds while clock-enable stays low and ends on the edge where it rises. The refresh command on that entry edge also raises `err`.
- R10: `clk_gate` is low in power down, self refresh and clock suspend, and high in run and recovery.
- R11: A synchronous high `rst` puts the controller in run, with `err` low and the recovery timer cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock-enable level as sampled this cycle |
| all_idle | input | 1 | Every bank is precharged |
| bank_active | input | 1 | At least one bank holds an open row |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| pwr_state | output | 3 | Current power state code |
| clk_gate | output | 1 | High when the internal clock may run |
| err | output | 1 | One-cycle pulse on an illegal entry, exit or recovery command |

## Verification
The properties assume that clock-enable stays high for the whole recovery window and that the bank flags describe a real bank state. The properties do not model a low clock-enable arriving during recovery. The stimulus keeps clock-enable high from each self-refresh exit until the state has returned to run. It also changes `all_idle` and `bank_active` only while the controller is running.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

    typedef enum logic [2:0] {
        PS_RUN   = 3'd0,
        PS_PDN   = 3'd1,
        PS_SREF  = 3'd2,
        PS_SUSP  = 3'd3,
        PS_RECOV = 3'd4
    } pwr_state_e;

    typedef enum logic [1:0] {
        CK_HOLD_HI = 2'd0,
        CK_FALL    = 2'd1,
        CK_RISE    = 2'd2,
        CK_HOLD_LO = 2'd3
    } cke_edge_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    typedef struct packed {
        logic idle_cmd;   // deselect or no-operation
        logic refresh;    // refresh code with chip selected
    } cmd_class_t;

    function automatic cmd_class_t classify_cmd(input cmd_pins_t c);
        cmd_class_t r;
        r.idle_cmd = c.cs_n | (c.ras_n & c.cas_n & c.we_n);
        r.refresh  = ~c.cs_n & ~c.ras_n & ~c.cas_n & c.we_n;
        return r;
    endfunction

    function automatic cke_edge_e cke_pair(input logic prev, input logic now);
        case ({prev, now})
            2'b11:   return CK_HOLD_HI;
            2'b10:   return CK_FALL;
            2'b01:   return CK_RISE;
            default: return CK_HOLD_LO;
        endcase
    endfunction

    function automatic logic gate_open(input pwr_state_e s);
        return (s == PS_RUN) || (s == PS_RECOV);
    endfunction

endpackage

// File: rtl/sdram_pwr_cmd_class.sv
module sdram_pwr_cmd_class
    import sdram_pwr_pkg::*;
(
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    output cmd_class_t cls
);
    cmd_pins_t pins;

    always_comb begin
        pins.cs_n  = cs_n;
        pins.ras_n = ras_n;
        pins.cas_n = cas_n;
        pins.we_n  = we_n;
        cls        = classify_cmd(pins);
    end
endmodule

// File: rtl/sdram_pwr_cke_track.sv
module sdram_pwr_cke_track
    import sdram_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cke,
    output cke_edge_e edge_kind
);
    logic cke_prev;

    always_ff @(posedge clk) begin
        if (rst) cke_prev <= 1'b1;
        else     cke_prev <= cke;
    end

    always_comb edge_kind = cke_pair(cke_prev, cke);
endmodule

// File: rtl/sdram_pwr_recov_timer.sv
module sdram_pwr_recov_timer #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(CYC) + 1;
    localparam logic [CW-1:0] START = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (load)               cnt <= START;
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end

    always_comb expired = (cnt == '0);
endmodule

// File: rtl/sdram_pwr_ctl.sv
module sdram_pwr_ctl
    import sdram_pwr_pkg::*;
#(
    parameter int RECOV_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cke,
    input  logic       all_idle,
    input  logic       bank_active,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    output logic [2:0] pwr_state,
    output logic       clk_gate,
    output logic       err
);
    cmd_class_t cls;
    cke_edge_e  edge_kind;
    pwr_state_e st_q, st_d;
    logic       err_d, err_q;
    logic       tm_load, tm_expired;
    logic       sleep_ok;

    sdram_pwr_cmd_class u_cls (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cls  (cls)
    );

    sdram_pwr_cke_track u_cke (
        .clk      (clk),
        .rst      (rst),
        .cke      (cke),
        .edge_kind(edge_kind)
    );

    sdram_pwr_recov_timer #(.CYC(RECOV_CYC)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load   (tm_load),
        .run    (st_q == PS_RECOV),
        .expired(tm_expired)
    );

    always_comb sleep_ok = all_idle & ~bank_active;

    always_comb begin
        st_d    = st_q;
        err_d   = 1'b0;
        tm_load = 1'b0;
        case (st_q)
            PS_RUN: begin
                if (edge_kind == CK_FALL) begin
                    if (sleep_ok) begin
                        if (cls.refresh)       st_d = PS_SREF;
                        else if (cls.idle_cmd) st_d = PS_PDN;
                        else begin
                            st_d  = PS_PDN;
                            err_d = 1'b1;
                        end
                    end else begin
                        st_d  = PS_SUSP;
                        err_d = cls.refresh;
                    end
                end
            end
            PS_PDN: begin
                if (edge_kind == CK_RISE) st_d = PS_RUN;
            end
            PS_SREF: begin
                if (edge_kind == CK_RISE) begin
                    st_d    = PS_RECOV;
                    tm_load = 1'b1;
                    err_d   = ~cls.idle_cmd;
                end
            end
            PS_SUSP: begin
                if (edge_kind == CK_RISE) st_d = PS_RUN;
            end
            PS_RECOV: begin
                err_d = ~cls.idle_cmd;
                if (tm_expired) st_d = PS_RUN;
            end
            default: st_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PS_RUN;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            err_q <= err_d;
        end
    end

    always_comb begin
        pwr_state = st_q;
        clk_gate  = gate_open(st_q);
        err       = err_q;
    end
endmodule

// File: rtl/sdram_pwr_ctl_chk.sv
module sdram_pwr_ctl_chk
    import sdram_pwr_pkg::*;
#(
    parameter int RECOV_CYC = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       cke,
    input logic       all_idle,
    input logic       bank_active,
    input logic [2:0] pwr_state,
    input logic       clk_gate,
    input logic       err
);
    localparam int RW = $clog2(RECOV_CYC + 1) + 1;
    localparam logic [RW-1:0] LAST = RW'(RECOV_CYC - 1);

    logic [RW-1:0] rc;

    always_ff @(posedge clk) begin
        if (rst)                      rc <= '0;
        else if (pwr_state == PS_RECOV) rc <= rc + 1'b1;
        else                          rc <= '0;
    end

    p_sleep_needs_idle_r2: assert property (@(posedge clk) disable iff (rst)
        ((pwr_state == PS_SREF || pwr_state == PS_PDN) && $past(pwr_state) == PS_RUN)
        |-> ($past(all_idle) && !$past(bank_active)));

    p_hold_low_r5: assert property (@(posedge clk) disable iff (rst)
        ((pwr_state == PS_PDN || pwr_state == PS_SREF) && !cke)
        |=> (pwr_state == $past(pwr_state)));

    p_sref_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PS_SREF) |=> (pwr_state == PS_SREF || pwr_state == PS_RECOV));

    p_recov_len_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(pwr_state) == PS_RECOV && pwr_state != PS_RECOV)
        |-> ($past(rc) == LAST && pwr_state == PS_RUN));

    p_susp_exit_r9: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PS_SUSP && cke) |=> (pwr_state == PS_RUN));

    p_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !clk_gate |-> (pwr_state == PS_PDN || pwr_state == PS_SREF || pwr_state == PS_SUSP));

    p_reset_r11: assert property (@(posedge clk)
        rst |=> (pwr_state == PS_RUN && !err));
endmodule

bind sdram_pwr_ctl sdram_pwr_ctl_chk #(.RECOV_CYC(RECOV_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cke        (cke),
    .all_idle   (all_idle),
    .bank_active(bank_active),
    .pwr_state  (pwr_state),
    .clk_gate   (clk_gate),
    .err        (err)
);

// File: tb/sdram_pwr_ctl_tb.sv
module sdram_pwr_ctl_tb;
    localparam int RC = 4;
    localparam logic [3:0] C_NOP = 4'b0111, C_DES = 4'b1111, C_REF = 4'b0001,
                           C_ACT = 4'b0011, C_RD  = 4'b0101;

    logic clk = 1'b0, rst = 1'b1, cke = 1'b1, all_idle = 1'b1, bank_active = 1'b0;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0] pwr_state;
    logic clk_gate, err;

    typedef struct {
        logic [2:0] st;
        logic       er;
        string      tag;
    } exp_t;
    exp_t sb[$];

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdram_pwr_ctl #(.RECOV_CYC(RC)) u_dut (
        .clk(clk), .rst(rst), .cke(cke), .all_idle(all_idle),
        .bank_active(bank_active), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .pwr_state(pwr_state),
        .clk_gate(clk_gate), .err(err)
    );

    task automatic step(input logic r, input logic k, input logic [3:0] c,
                        input logic idl, input logic act,
                        input logic [2:0] es, input logic ee, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; cke = k; {cs_n, ras_n, cas_n, we_n} = c;
        all_idle = idl; bank_active = act;
        e.st = es; e.er = ee; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares one expected item per edge, 1 ns after it
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            logic eg;
            e  = sb.pop_front();
            eg = (e.st == 3'd0) || (e.st == 3'd4);
            n_chk += 3;
            if (pwr_state !== e.st) begin
                n_bad++;
                $display("FAIL %s state: actual %0d expected %0d", e.tag, pwr_state, e.st);
            end
            if (clk_gate !== eg) begin
                n_bad++;
                $display("FAIL R10 (%s) gate: actual %0b expected %0b", e.tag, clk_gate, eg);
            end
            if (err !== e.er) begin
                n_bad++;
                $display("FAIL %s err: actual %0b expected %0b", e.tag, err, e.er);
            end
        end
    end

    initial begin
        // R11 reset state
        step(1, 1, C_NOP, 1, 0, 3'd0, 0, "R11");
        // R1 steady high
        step(0, 1, C_NOP, 1, 0, 3'd0, 0, "R1");
        step(0, 1, C_ACT, 0, 1, 3'd0, 0, "R1");
        // R3 power down via NOP, R5 hold, R7 exit with other command
        step(0, 1, C_NOP, 1, 0, 3'd0, 0, "R1");
        step(0, 0, C_NOP, 1, 0, 3'd1, 0, "R3");
        step(0, 0, C_RD,  1, 0, 3'd1, 0, "R5");
        step(0, 1, C_RD,  1, 0, 3'd0, 0, "R7");
        // R3 power down via deselect
        step(0, 0, C_DES, 1, 0, 3'd1, 0, "R3");
        step(0, 1, C_NOP, 1, 0, 3'd0, 0, "R7");
        // R4 illegal entry
        step(0, 0, C_ACT, 1, 0, 3'd1, 1, "R4");
        step(0, 1, C_NOP, 1, 0, 3'd0, 0, "R7");
        // R2 self refresh, R5 hold, R6 clean exit and recovery length
        step(0, 0, C_REF, 1, 0, 3'd2, 0, "R2");
        step(0, 0, C_ACT, 1, 0, 3'd2, 0, "R5");
        step(0, 0, C_NOP, 1, 0, 3'd2, 0, "R5");
        step(0, 1, C_NOP, 1, 0, 3'd4, 0, "R6");
        step(0, 1, C_NOP, 1, 0, 3'd4, 0, "R6");
        step(0, 1, C_DES, 1, 0, 3'd4, 0, "R6");
        step(0, 1, C_NOP, 1, 0, 3'd4, 0, "R6");
        step(0, 1, C_NOP, 1, 0, 3'd0, 0, "R6");
        // R6 illegal exit, R8 command during recovery
        step(0, 0, C_REF, 1, 0, 3'd2, 0, "R2");
        step(0, 1, C_RD,  1, 0, 3'd4, 1, "R6");
        step(0, 1, C_ACT, 1, 0, 3'd4, 1, "R8");
        step(0, 1, C_NOP, 1, 0, 3'd4, 0, "R8");
        step(0, 1, C_NOP, 1, 0, 3'd4, 0, "R8");
        step(0, 1, C_NOP, 1, 0, 3'd0, 0, "R8");
        // R9 clock suspend with a bank open
        step(0, 0, C_NOP, 0, 1, 3'd3, 0, "R9");
        step(0, 0, C_RD,  0, 1, 3'd3, 0, "R9");
        step(0, 1, C_NOP, 0, 1, 3'd0, 0, "R9");
        // R9 refresh on entry edge while a bank is open
        step(0, 0, C_REF, 1, 1, 3'd3, 1, "R9");
        step(0, 1, C_NOP, 1, 1, 3'd0, 0, "R9");
        // R9 banks not idle, no bank flagged active
        step(0, 0, C_DES, 0, 0, 3'd3, 0, "R9");
        step(0, 1, C_DES, 0, 0, 3'd0, 0, "R9");
        // R11 reset out of a sleep state
        step(0, 0, C_REF, 1, 0, 3'd2, 0, "R2");
        step(1, 0, C_NOP, 1, 0, 3'd0, 0, "R11");
        step(0, 1, C_NOP, 1, 0, 3'd0, 0, "R11");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule